// File: doc/BRIEF.md
# Per-Hart Run Control Register

This block holds the run-control state for a small array of harts. A single write carries a hart index, a multi-select flag, a per-hart selection mask and a set of command bits. The block applies each command to every hart in the selected set. The commands are: halt request, one-shot resume, hart reset request, reset acknowledge, and set or clear of halt-on-reset. Each hart reports two status inputs: whether it is halted and whether it is held in reset. Each hart receives a halt request, a reset request and a resume request. A module-enable input acts as an active-low clear of all per-hart state.

The selection carried by the most recent accepted write is stored. Six any/all summary outputs are computed over that stored group: halted, have-reset and resume-acknowledge. Each hart has a small resume handshake machine with these states:
- `RS_IDLE`: no resume since enable.
- `RS_PEND`: resume issued, waiting for the hart to run.
- `RS_ACKED`: the hart left the halted state after a resume.

Its transitions are:
- `RS_IDLE`→`RS_PEND` and `RS_ACKED`→`RS_PEND` on an accepted resume.
- `RS_PEND`→`RS_ACKED` when the hart reports it is no longer halted.
- Any state→`RS_IDLE` while enable is low.

Top module: `run_ctl_reg`

## Requirements
- R1: With `wr_multi`=0 the selected set is only hart `wr_idx`. With `wr_multi`=1 it is hart `wr_idx` together with every hart whose `wr_mask` bit is 1. The same write uses this new selection for its commands.
- R2: An accepted write stores `wr_halt` into the halt request of every selected hart. Unselected harts keep their value. `halt_req` shows the new value from the cycle after the write.
- R3: Consider a selected hart that is halted in the write cycle, in a write with `wr_resume`=1 and `wr_halt`=0. From the next cycle it gets `resume_req`=1 and its resume-ack bit is cleared. `resume_req` stays 1 until the hart reports not halted, and then the ack bit becomes 1 on the next cycle. A hart not halted at the write is unaffected.
- R4: A write with `wr_halt`=1 never starts a resume, whatever `wr_resume` is.
- R5: An accepted write stores `wr_hartreset` into `reset_req` of every selected hart.
- R6: `wr_set_rh`=1 stores a per-hart halt-on-reset bit for the selected harts, unless `wr_clr_rh`=1 in the same write; clear wins. The bit is never cleared automatically. When `hart_in_reset` of a hart with the bit set goes from 1 to 0, that hart's `halt_req` becomes 1 on the next cycle, and this repeats on every later deassertion.
- R7: A hart's have-reset flag is set by the 1-to-0 transition of its `hart_in_reset`, visible the next cycle. `wr_ackreset`=1 clears it for the selected harts. A deassertion in the same cycle wins over the clear.
- R8: For each of halted, have-reset and resume-ack, the `any_*` output is 1 when at least one hart of the stored group has the flag. The `all_*` output is 1 when every hart of the group has it. The group is the selection of the last accepted write, and is hart 0 after reset.
- R9: While `enable`=0, all per-hart state is held at 0: halt request, reset request, halt-on-reset, have-reset and the resume machine in `RS_IDLE`. Writes are ignored, including their selection.
- R10: After `rst_n` reset, all request outputs and all summary outputs are 0 while all harts are running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Module enable; 0 clears per-hart state |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | IDX_W | Indexed hart of the write |
| wr_multi | input | 1 | Include harts flagged in `wr_mask` |
| wr_mask | input | NUM_HARTS | Per-hart selection mask |
| wr_halt | input | 1 | Halt request value for selected harts |
| wr_resume | input | 1 | One-shot resume of selected halted harts |
| wr_hartreset | input | 1 | Reset request value for selected harts |
| wr_ackreset | input | 1 | Clear have-reset of selected harts |
| wr_set_rh | input | 1 | Set halt-on-reset of selected harts |
| wr_clr_rh | input | 1 | Clear halt-on-reset of selected harts (wins) |
| hart_halted | input | NUM_HARTS | Hart is halted |
| hart_in_reset | input | NUM_HARTS | Hart is held in reset |
| halt_req | output | NUM_HARTS | Halt request per hart |
| reset_req | output | NUM_HARTS | Reset request per hart |
| resume_req | output | NUM_HARTS | Resume request per hart |
| any_halted | output | 1 | Some hart of the group is halted |
| all_halted | output | 1 | Every hart of the group is halted |
| any_have_reset | output | 1 | Some hart of the group has unacknowledged reset |
| all_have_reset | output | 1 | Every hart of the group has unacknowledged reset |
| any_resume_ack | output | 1 | Some hart of the group acknowledged its resume |
| all_resume_ack | output | 1 | Every hart of the group acknowledged its resume |

## Verification
The bench goes after several corner cases:
- A multi-hart resume where only some harts are halted: a design that skips the halted test would resume running harts and lose their acks.
- A write with halt and resume both set: a design that ignores the halt priority would raise `resume_req`.
- A set and clear of halt-on-reset in one write: a design that lets set win would halt that hart after its next reset pulse.
- Repeated reset pulses: a design that clears the latch automatically would miss the second halt.
- Summaries over a group where only some harts carry a flag: this catches any/all inversions.
- A write issued while disabled: a design that still applies it would show requests after enable returns.

// File: rtl/rc_pkg.sv
package rc_pkg;

    typedef enum logic [1:0] {
        RS_IDLE  = 2'd0,
        RS_PEND  = 2'd1,
        RS_ACKED = 2'd2
    } resume_state_e;

    typedef struct packed {
        logic halt;
        logic resume;
        logic hartreset;
        logic ackreset;
        logic set_rh;
        logic clr_rh;
    } wr_cmd_t;

endpackage

// File: rtl/rc_select.sv
module rc_select #(
    parameter int NUM_HARTS = 4,
    parameter int IDX_W     = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1
) (
    input  logic [IDX_W-1:0]     idx,
    input  logic                 multi,
    input  logic [NUM_HARTS-1:0] mask,
    output logic [NUM_HARTS-1:0] sel
);
    for (genvar g = 0; g < NUM_HARTS; g++) begin : g_sel
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);
        assign sel[g] = (idx == MY_IDX) | (multi & mask[g]);
    end
endmodule

// File: rtl/rc_hart_slot.sv
module rc_hart_slot
    import rc_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    enable,
    input  logic    apply,
    input  wr_cmd_t cmd,
    input  logic    halted,
    input  logic    in_reset,
    output logic    halt_req,
    output logic    reset_req,
    output logic    resume_req,
    output logic    have_reset,
    output logic    resume_ack
);
    resume_state_e state_q, state_d;
    logic halt_q, rreq_q, hor_q, hr_q, prev_rst_q;
    logic deassert, go;

    assign deassert = prev_rst_q & ~in_reset;
    assign go       = apply & cmd.resume & ~cmd.halt & halted;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       state_q <= RS_IDLE;
        else if (!enable) state_q <= RS_IDLE;
        else              state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RS_IDLE:  if (go) state_d = RS_PEND;
            RS_PEND:  if (!halted) state_d = RS_ACKED;
            RS_ACKED: if (go) state_d = RS_PEND;
            default:  state_d = RS_IDLE;
        endcase
    end

    // outputs of the resume machine
    always_comb begin
        resume_req = 1'b0;
        resume_ack = 1'b0;
        unique case (state_q)
            RS_IDLE:  ;
            RS_PEND:  resume_req = 1'b1;
            RS_ACKED: resume_ack = 1'b1;
            default:  ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_rst_q <= 1'b0;
        else        prev_rst_q <= in_reset;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            halt_q <= 1'b0;
            rreq_q <= 1'b0;
            hor_q  <= 1'b0;
            hr_q   <= 1'b0;
        end else if (!enable) begin
            halt_q <= 1'b0;
            rreq_q <= 1'b0;
            hor_q  <= 1'b0;
            hr_q   <= 1'b0;
        end else begin
            if (apply) begin
                halt_q <= cmd.halt;
                rreq_q <= cmd.hartreset;
                if (cmd.clr_rh)      hor_q <= 1'b0;
                else if (cmd.set_rh) hor_q <= 1'b1;
                if (cmd.ackreset)    hr_q  <= 1'b0;
            end
            if (deassert) begin
                hr_q <= 1'b1;
                if (hor_q) halt_q <= 1'b1;
            end
        end
    end

    assign halt_req   = halt_q;
    assign reset_req  = rreq_q;
    assign have_reset = hr_q;
endmodule

// File: rtl/rc_summary.sv
module rc_summary #(
    parameter int NUM_HARTS = 4
) (
    input  logic [NUM_HARTS-1:0] group,
    input  logic [NUM_HARTS-1:0] flags,
    output logic                 any_set,
    output logic                 all_set
);
    assign any_set = |(group & flags);
    assign all_set = (|group) & (&(~group | flags));
endmodule

// File: rtl/run_ctl_reg.sv
module run_ctl_reg
    import rc_pkg::*;
#(
    parameter int NUM_HARTS = 4,
    parameter int IDX_W     = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic                 wr_multi,
    input  logic [NUM_HARTS-1:0] wr_mask,
    input  logic                 wr_halt,
    input  logic                 wr_resume,
    input  logic                 wr_hartreset,
    input  logic                 wr_ackreset,
    input  logic                 wr_set_rh,
    input  logic                 wr_clr_rh,
    input  logic [NUM_HARTS-1:0] hart_halted,
    input  logic [NUM_HARTS-1:0] hart_in_reset,
    output logic [NUM_HARTS-1:0] halt_req,
    output logic [NUM_HARTS-1:0] reset_req,
    output logic [NUM_HARTS-1:0] resume_req,
    output logic                 any_halted,
    output logic                 all_halted,
    output logic                 any_have_reset,
    output logic                 all_have_reset,
    output logic                 any_resume_ack,
    output logic                 all_resume_ack
);
    localparam logic [NUM_HARTS-1:0] GROUP_RST = NUM_HARTS'(1);

    logic [NUM_HARTS-1:0] sel, group_q, have_reset, resume_ack;
    logic                 accept;
    wr_cmd_t              cmd;

    assign accept = wr_en & enable;
    assign cmd = '{halt: wr_halt, resume: wr_resume, hartreset: wr_hartreset,
                   ackreset: wr_ackreset, set_rh: wr_set_rh, clr_rh: wr_clr_rh};

    rc_select #(.NUM_HARTS(NUM_HARTS), .IDX_W(IDX_W)) sel_i (
        .idx(wr_idx), .multi(wr_multi), .mask(wr_mask), .sel(sel)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      group_q <= GROUP_RST;
        else if (accept) group_q <= sel;
    end

    for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
        rc_hart_slot slot_i (
            .clk(clk), .rst_n(rst_n), .enable(enable),
            .apply(accept & sel[h]), .cmd(cmd),
            .halted(hart_halted[h]), .in_reset(hart_in_reset[h]),
            .halt_req(halt_req[h]), .reset_req(reset_req[h]),
            .resume_req(resume_req[h]), .have_reset(have_reset[h]),
            .resume_ack(resume_ack[h])
        );
    end

    rc_summary #(.NUM_HARTS(NUM_HARTS)) sum_halt_i (
        .group(group_q), .flags(hart_halted), .any_set(any_halted), .all_set(all_halted)
    );
    rc_summary #(.NUM_HARTS(NUM_HARTS)) sum_hr_i (
        .group(group_q), .flags(have_reset), .any_set(any_have_reset), .all_set(all_have_reset)
    );
    rc_summary #(.NUM_HARTS(NUM_HARTS)) sum_ack_i (
        .group(group_q), .flags(resume_ack), .any_set(any_resume_ack), .all_set(all_resume_ack)
    );
endmodule

// File: rtl/rc_checker.sv
module rc_checker #(
    parameter int NUM_HARTS = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 enable,
    input logic                 wr_en,
    input logic                 wr_multi,
    input logic [NUM_HARTS-1:0] wr_mask,
    input logic                 wr_halt,
    input logic                 wr_hartreset,
    input logic                 wr_ackreset,
    input logic [NUM_HARTS-1:0] hart_halted,
    input logic [NUM_HARTS-1:0] hart_in_reset,
    input logic [NUM_HARTS-1:0] halt_req,
    input logic [NUM_HARTS-1:0] reset_req,
    input logic [NUM_HARTS-1:0] resume_req,
    input logic                 any_halted,
    input logic                 all_halted,
    input logic                 any_have_reset,
    input logic                 all_have_reset,
    input logic                 any_resume_ack,
    input logic                 all_resume_ack
);
    logic [NUM_HARTS-1:0] prev_rst;
    logic                 any_deassert, wr_all;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_rst <= '0;
        else        prev_rst <= hart_in_reset;
    end
    assign any_deassert = |(prev_rst & ~hart_in_reset);
    assign wr_all       = wr_en & enable & wr_multi & (&wr_mask);

    for (genvar h = 0; h < NUM_HARTS; h++) begin : g_h
        AST_RESUME_ONLY_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(resume_req[h]) |-> $past(hart_halted[h])); // R3
        AST_HALT_BLOCKS_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(resume_req[h]) |-> !$past(wr_en & wr_halt)); // R4
    end

    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (halt_req == '0) && (reset_req == '0) && (resume_req == '0)); // R9
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_all && wr_ackreset && !any_deassert) |=> !any_have_reset); // R7
    AST_RESET_REQ_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        wr_all |=> (reset_req == {NUM_HARTS{$past(wr_hartreset)}})); // R5
    AST_ALL_HAS_ANY: assert property (@(posedge clk) disable iff (!rst_n)
        (!all_halted || any_halted) && (!all_have_reset || any_have_reset)
        && (!all_resume_ack || any_resume_ack)); // R8
endmodule

bind run_ctl_reg rc_checker #(.NUM_HARTS(NUM_HARTS)) chk_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .wr_en(wr_en), .wr_multi(wr_multi),
    .wr_mask(wr_mask), .wr_halt(wr_halt), .wr_hartreset(wr_hartreset),
    .wr_ackreset(wr_ackreset), .hart_halted(hart_halted), .hart_in_reset(hart_in_reset),
    .halt_req(halt_req), .reset_req(reset_req), .resume_req(resume_req),
    .any_halted(any_halted), .all_halted(all_halted), .any_have_reset(any_have_reset),
    .all_have_reset(all_have_reset), .any_resume_ack(any_resume_ack),
    .all_resume_ack(all_resume_ack)
);

// File: tb/run_ctl_reg_tb_top.sv
`timescale 1ns/1ps
module run_ctl_reg_tb_top;
    localparam int N  = 4;
    localparam int IW = 2;
    localparam int OW = 3*N + 6;

    logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0;
    logic wr_en = 0, wr_multi = 0, wr_halt = 0, wr_resume = 0, wr_hartreset = 0;
    logic wr_ackreset = 0, wr_set_rh = 0, wr_clr_rh = 0;
    logic [IW-1:0] wr_idx = '0;
    logic [N-1:0]  wr_mask = '0, hart_halted = '0, hart_in_reset = '0;
    logic [N-1:0]  halt_req, reset_req, resume_req;
    logic any_halted, all_halted, any_have_reset, all_have_reset, any_resume_ack, all_resume_ack;

    always #2.5 clk = ~clk;

    run_ctl_reg #(.NUM_HARTS(N)) dut_i (.*);

    typedef struct { string tag; logic [OW-1:0] exp; } item_t;
    item_t q[$];
    int vectors = 0, miscompares = 0;
    bit done = 0;

    // reference state derived from the requirements
    logic [N-1:0] m_halt, m_rreq, m_hor, m_hr, m_pend, m_ack, m_grp, m_prev;

    function automatic logic [1:0] summ(input logic [N-1:0] g, input logic [N-1:0] f);
        return {|(g & f), (|g) & (&(~g | f))};
    endfunction

    task automatic step(input string tag);
        logic [N-1:0] sel, deas, old_hor;
        logic [OW-1:0] e;
        item_t it;
        deas = m_prev & ~hart_in_reset;
        old_hor = m_hor;
        if (!enable) begin
            m_halt = '0; m_rreq = '0; m_hor = '0; m_hr = '0; m_pend = '0; m_ack = '0;
        end else begin
            sel = '0;
            if (wr_en) begin
                for (int i = 0; i < N; i++) sel[i] = (wr_idx == i) | (wr_multi & wr_mask[i]);
                m_grp = sel;
            end
            for (int i = 0; i < N; i++) begin
                logic go;
                go = sel[i] & wr_resume & ~wr_halt & hart_halted[i];
                if (m_pend[i]) begin
                    if (!hart_halted[i]) begin m_pend[i] = 0; m_ack[i] = 1; end
                end else if (go) begin
                    m_pend[i] = 1; m_ack[i] = 0;
                end
                if (sel[i]) begin
                    m_halt[i] = wr_halt;
                    m_rreq[i] = wr_hartreset;
                    if (wr_clr_rh) m_hor[i] = 0; else if (wr_set_rh) m_hor[i] = 1;
                    if (wr_ackreset) m_hr[i] = 0;
                end
                if (deas[i]) begin
                    m_hr[i] = 1;
                    if (old_hor[i]) m_halt[i] = 1;
                end
            end
        end
        m_prev = hart_in_reset;
        @(posedge clk);
        e = {m_halt, m_rreq, m_pend, summ(m_grp, hart_halted), summ(m_grp, m_hr), summ(m_grp, m_ack)};
        it.tag = tag; it.exp = e;
        q.push_back(it);
        @(negedge clk); #1;
    endtask

    // cmd bits: {halt, resume, hartreset, ackreset, set_rh, clr_rh}
    task automatic write_cmd(input int idx, input bit multi, input logic [N-1:0] mask,
                             input logic [5:0] c, input string tag);
        wr_en = 1; wr_idx = IW'(idx); wr_multi = multi; wr_mask = mask;
        {wr_halt, wr_resume, wr_hartreset, wr_ackreset, wr_set_rh, wr_clr_rh} = c;
        step(tag);
        wr_en = 0; wr_multi = 0; wr_mask = '0;
        {wr_halt, wr_resume, wr_hartreset, wr_ackreset, wr_set_rh, wr_clr_rh} = '0;
    endtask

    // monitor
    always @(negedge clk) begin
        if (q.size() > 0) begin
            item_t it;
            logic [OW-1:0] obs;
            it = q.pop_front();
            obs = {halt_req, reset_req, resume_req, any_halted, all_halted,
                   any_have_reset, all_have_reset, any_resume_ack, all_resume_ack};
            vectors++;
            if (obs !== it.exp) begin
                miscompares++;
                $display("FAIL %s actual %h expected %h", it.tag, obs, it.exp);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog R10 actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        m_halt = '0; m_rreq = '0; m_hor = '0; m_hr = '0; m_pend = '0; m_ack = '0;
        m_grp = 4'b0001; m_prev = '0;
        repeat (3) @(negedge clk);
        rst_n = 1; enable = 1; #1;
        step("R10 reset state");
        step("R10 idle");
        // R2 single hart halt set and clear
        write_cmd(2, 0, 4'b0000, 6'b100000, "R2 halt hart2");
        write_cmd(2, 0, 4'b1111, 6'b000000, "R1 mask ignored single");
        // R1 multi selection
        write_cmd(0, 1, 4'b1010, 6'b100000, "R1 multi halt");
        write_cmd(1, 0, 4'b0000, 6'b001000, "R5 reset req hart1");
        write_cmd(1, 1, 4'b0100, 6'b000000, "R5 clear reset req");
        write_cmd(0, 1, 4'b1111, 6'b000000, "R2 clear halts");
        // R3 resume only halted harts
        hart_halted = 4'b0100;
        step("R8 halted any");
        write_cmd(0, 1, 4'b1111, 6'b010000, "R3 resume group");
        step("R3 resume held while halted");
        hart_halted = 4'b0000;
        step("R3 ack after run");
        step("R8 resume ack any not all");
        // R4 halt with resume
        hart_halted = 4'b1111;
        step("R8 all halted");
        write_cmd(0, 1, 4'b1111, 6'b110000, "R4 halt blocks resume");
        step("R4 no resume");
        write_cmd(0, 1, 4'b1111, 6'b010000, "R3 resume all");
        hart_halted = 4'b0000;
        step("R3 all ack");
        // R6 halt-on-reset
        write_cmd(1, 0, 4'b0000, 6'b000011, "R6 set and clear hart1");
        write_cmd(3, 0, 4'b0000, 6'b000010, "R6 set hart3");
        write_cmd(1, 1, 4'b1000, 6'b000000, "R8 group 1 and 3");
        hart_in_reset = 4'b1010;
        step("R7 in reset");
        hart_in_reset = 4'b0000;
        step("R6 halt after deassert");
        step("R7 have reset");
        write_cmd(3, 0, 4'b0000, 6'b000000, "R6 clear halt hart3");
        hart_in_reset = 4'b1000;
        step("R6 second pulse");
        hart_in_reset = 4'b0000;
        step("R6 latch kept");
        step("R6 halt again");
        // R7 acknowledge
        write_cmd(1, 0, 4'b0000, 6'b100100, "R7 ack hart1");
        write_cmd(0, 1, 4'b1111, 6'b100000, "R8 group all");
        write_cmd(0, 1, 4'b1111, 6'b100100, "R7 ack all");
        // R7 deassert beats ack
        hart_in_reset = 4'b0001;
        step("R7 reset hart0");
        hart_in_reset = 4'b0000;
        wr_en = 1; wr_idx = 0; wr_multi = 0; wr_halt = 1; wr_ackreset = 1;
        step("R7 set wins over ack");
        wr_en = 0; wr_halt = 0; wr_ackreset = 0;
        // R9 disable
        write_cmd(0, 1, 4'b1111, 6'b101010, "R9 prepare");
        hart_halted = 4'b0110;
        write_cmd(0, 1, 4'b1111, 6'b011000, "R9 resume some");
        enable = 0;
        step("R9 cleared");
        write_cmd(2, 0, 4'b0000, 6'b101000, "R9 write ignored");
        enable = 1;
        step("R9 re-enabled empty");
        hart_in_reset = 4'b1111;
        step("R9 reset after enable");
        hart_in_reset = 4'b0000;
        step("R9 no halt-on-reset left");
        step("R9 final");
        repeat (2) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule